// File: doc/BRIEF.md
# Port-Write Receive Unit

This block accepts maintenance port-write packets from a link-side word stream. It stores one packet at a time into a memory buffer. A packet is sixteen 32-bit words. Each word goes to memory as it arrives, at a byte address formed from an extended upper base register and a lower base register, plus four bytes per word. When the sixteenth word of a stored packet is written, the unit marks its single-entry queue as full and raises a queue-full interrupt flag. No further packet is stored until software issues a clear-queue command. Packets that arrive while the queue is full are consumed at full rate and thrown away, and a discard flag records that this happened.

Software controls the unit through a small register interface. A mode register enables the unit, sets the snoop attribute for memory writes, enables the two interrupt sources and carries the self-clearing clear-queue command. A status register reports queue full, busy, discard, queue-full interrupt and transaction error. A transaction error comes from the link side. It can be cleared only while the unit is disabled.

Top module: `pw_rx_unit`

## Requirements
- R1: After reset, the mode register (address 0) and the status register (address 1) read 0, `irq` is 0 and `link_ready` is 0.
- R2: `link_ready` equals the enable bit (mode bit 0). While the unit is disabled, no memory write is issued, even if `link_valid` is held high.
- R3: A packet of 16 accepted words that starts while the queue is empty is written to memory. Word i goes to address {ext_base, base} + 4*i, where base is register 2 and ext_base is the low 4 bits of register 3. Each write carries that word's data and `mem_wr_snoop` equal to mode bit 20. Gaps in `link_valid` do not change this.
- R4: When the last word of a stored packet is accepted, status bit 20 (queue full) and status bit 4 (queue-full interrupt) become 1.
- R5: While queue full is 1, a packet whose first word arrives is dropped. None of its 16 words produces a memory write. After its 16th word, status bit 3 (discarded) is 1.
- R6: Writing mode with bit 1 set clears queue full. Mode bit 1 always reads 0. After the clear, the next packet is stored again.
- R7: Status bits 7, 4 and 3 clear when 1 is written to them (bit 7 subject to R8). Writing 0 leaves the status unchanged. Writing 1 to bit 4 does not clear queue full.
- R8: A `link_err` pulse while the unit is enabled sets status bit 7. Writing 1 to bit 7 while mode bit 0 is 1 is ignored. The same write while mode bit 0 is 0 clears it.
- R9: `irq` = (status bit 4 AND mode bit 8) OR (status bit 7 AND mode bit 5).
- R10: Status bit 2 (busy) is 1 after the first word of a stored packet is accepted and until its last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 base, 3 extended base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| link_valid | input | 1 | Link word valid |
| link_ready | output | 1 | Unit accepts a link word |
| link_data | input | 32 | Link word |
| link_err | input | 1 | Transaction error pulse from the link side |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | 36 | Memory byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_snoop | output | 1 | Snoop attribute of the write |
| irq | output | 1 | Interrupt request |

## Verification
The storing path is tried three ways: with back-to-back words, with idle gaps between words, and with the unit disabled while `link_valid` stays high. These runs separate the address stepping from the valid handshake, and both of those from the enable gating. A packet sent while the queue is full shows whether the drop decision applies to the whole packet and not just its first word. Storing again after the clear-queue command shows that the release really reopens the queue. The error and interrupt patterns toggle each enable separately and try the error clear with the unit on and then off. This tells the enable-gated clear apart from a plain write-one-to-clear.

// File: rtl/pw_rx_pkg.sv
// Package: shared bit positions and register selects for the port-write receive unit.
// Assumes a 32-bit register data path.
package pw_rx_pkg;
    localparam int MODE_EN    = 0;
    localparam int MODE_CLRQ  = 1;
    localparam int MODE_EIE   = 5;
    localparam int MODE_QFIE  = 8;
    localparam int MODE_SNOOP = 20;

    localparam int ST_BUSY = 2;
    localparam int ST_DISC = 3;
    localparam int ST_QFI  = 4;
    localparam int ST_TE   = 7;
    localparam int ST_QF   = 20;

    typedef enum logic [1:0] {
        RA_MODE  = 2'd0,
        RA_STAT  = 2'd1,
        RA_BASE  = 2'd2,
        RA_XBASE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pw_rx_regs.sv
// Register file: mode, status and base registers, plus the interrupt output.
// Assumes store_done and drop_done are single-cycle pulses from the ingest path.
module pw_rx_regs
    import pw_rx_pkg::*;
#(
    parameter int EXT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 link_err,
    input  logic                 store_done,
    input  logic                 drop_done,
    input  logic                 busy,
    output logic                 en,
    output logic                 snoop,
    output logic [32+EXT_W-1:0]  base_addr,
    output logic                 qf,
    output logic                 irq
);
    logic             qfie_q, eie_q;
    logic             te_q, qfi_q, disc_q;
    logic [31:0]      base_q;
    logic [EXT_W-1:0] xbase_q;
    logic             wr_mode, wr_stat, clr_q;
    logic             unused_wdata;

    assign wr_mode      = reg_wr && (reg_addr == RA_MODE);
    assign wr_stat      = reg_wr && (reg_addr == RA_STAT);
    assign clr_q        = wr_mode && reg_wdata[MODE_CLRQ];
    assign unused_wdata = ^reg_wdata;

    // Mode fields and base registers, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            snoop   <= 1'b0;
            qfie_q  <= 1'b0;
            eie_q   <= 1'b0;
            base_q  <= '0;
            xbase_q <= '0;
        end else begin
            if (wr_mode) begin
                en     <= reg_wdata[MODE_EN];
                snoop  <= reg_wdata[MODE_SNOOP];
                qfie_q <= reg_wdata[MODE_QFIE];
                eie_q  <= reg_wdata[MODE_EIE];
            end
            if (reg_wr && reg_addr == RA_BASE)  base_q  <= reg_wdata;
            if (reg_wr && reg_addr == RA_XBASE) xbase_q <= reg_wdata[EXT_W-1:0];
        end
    end

    // Status flags: hardware sets have priority over software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qf     <= 1'b0;
            qfi_q  <= 1'b0;
            disc_q <= 1'b0;
            te_q   <= 1'b0;
        end else begin
            if (store_done)                     qf <= 1'b1;
            else if (clr_q)                     qf <= 1'b0;
            if (store_done)                     qfi_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_QFI])  qfi_q <= 1'b0;
            if (drop_done)                      disc_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_DISC]) disc_q <= 1'b0;
            if (link_err && en)                 te_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_TE] && !en) te_q <= 1'b0;
        end
    end

    // Read mux; the clear-queue bit is never stored, so it reads 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            RA_MODE: begin
                reg_rdata[MODE_EN]    = en;
                reg_rdata[MODE_SNOOP] = snoop;
                reg_rdata[MODE_QFIE]  = qfie_q;
                reg_rdata[MODE_EIE]   = eie_q;
            end
            RA_STAT: begin
                reg_rdata[ST_QF]   = qf;
                reg_rdata[ST_TE]   = te_q;
                reg_rdata[ST_QFI]  = qfi_q;
                reg_rdata[ST_DISC] = disc_q;
                reg_rdata[ST_BUSY] = busy;
            end
            RA_BASE:  reg_rdata = base_q;
            RA_XBASE: reg_rdata[EXT_W-1:0] = xbase_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign base_addr = {xbase_q, base_q};
    assign irq       = (qfi_q && qfie_q) || (te_q && eie_q);

    AST_TE_HELD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en && te_q) |=> te_q); // R8
    AST_QF_BRINGS_QFI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qf) |-> qfi_q); // R4
    AST_CLRQ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (qf && clr_q && !store_done) |=> !qf); // R6
endmodule

// File: rtl/pw_rx_ingest.sv
// Ingest path: counts link words, decides store or drop at the first word of a packet,
// and issues one registered memory write per stored word.
// Assumes a packet is exactly BEATS words; there is no end marker on the link.
module pw_rx_ingest #(
    parameter int BEATS = 16,
    parameter int EXT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 snoop,
    input  logic [32+EXT_W-1:0]  base_addr,
    input  logic                 qf,
    input  logic                 link_valid,
    input  logic [31:0]          link_data,
    output logic                 link_ready,
    output logic                 mem_wr_valid,
    output logic [32+EXT_W-1:0]  mem_wr_addr,
    output logic [31:0]          mem_wr_data,
    output logic                 mem_wr_snoop,
    output logic                 store_done,
    output logic                 drop_done,
    output logic                 busy
);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int ADDR_W = 32 + EXT_W;

    logic [BEAT_W-1:0] beat_cnt;
    logic              drop_q;
    logic              accept, first, last, cur_drop;
    logic [ADDR_W-1:0] offset;

    assign link_ready = en;
    assign accept     = link_valid && link_ready;
    assign first      = (beat_cnt == '0);
    assign last       = (beat_cnt == BEAT_W'(BEATS - 1));
    assign cur_drop   = first ? qf : drop_q;
    assign store_done = accept && last && !cur_drop;
    assign drop_done  = accept && last && cur_drop;
    assign busy       = !first && !drop_q;

    // Byte offset of the current word inside the message buffer.
    always_comb begin
        offset = '0;
        offset[BEAT_W+1:0] = {beat_cnt, 2'b00};
    end

    // Word counter and the per-packet drop decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
            drop_q   <= 1'b0;
        end else if (accept) begin
            beat_cnt <= last ? '0 : beat_cnt + 1'b1;
            if (first) drop_q <= qf;
        end
    end

    // Registered memory write for each stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
            mem_wr_snoop <= 1'b0;
        end else begin
            mem_wr_valid <= accept && !cur_drop;
            mem_wr_addr  <= base_addr + offset;
            mem_wr_data  <= link_data;
            mem_wr_snoop <= snoop;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mem_wr_valid); // R2
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && first && qf) |=> !mem_wr_valid); // R5
endmodule

// File: rtl/pw_rx_unit.sv
// Top: port-write receive unit with a single-entry queue released by a clear command.
// Assumes the memory side accepts a write every cycle.
module pw_rx_unit #(
    parameter int BEATS = 16,
    parameter int EXT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 link_valid,
    output logic                 link_ready,
    input  logic [31:0]          link_data,
    input  logic                 link_err,
    output logic                 mem_wr_valid,
    output logic [32+EXT_W-1:0]  mem_wr_addr,
    output logic [31:0]          mem_wr_data,
    output logic                 mem_wr_snoop,
    output logic                 irq
);
    logic                en, snoop, qf, store_done, drop_done, busy;
    logic [32+EXT_W-1:0] base_addr;

    pw_rx_regs #(.EXT_W(EXT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_err(link_err), .store_done(store_done), .drop_done(drop_done), .busy(busy),
        .en(en), .snoop(snoop), .base_addr(base_addr), .qf(qf), .irq(irq)
    );

    pw_rx_ingest #(.BEATS(BEATS), .EXT_W(EXT_W)) ingest_i (
        .clk(clk), .rst_n(rst_n),
        .en(en), .snoop(snoop), .base_addr(base_addr), .qf(qf),
        .link_valid(link_valid), .link_data(link_data), .link_ready(link_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_snoop(mem_wr_snoop),
        .store_done(store_done), .drop_done(drop_done), .busy(busy)
    );
endmodule

// File: tb/pw_rx_unit_tb.sv
// Scoreboard bench: the driver pushes expected memory writes, the monitor pops and compares.
module pw_rx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_valid = 1'b0;
    logic        link_ready;
    logic [31:0] link_data = '0;
    logic        link_err = 1'b0;
    logic        mem_wr_valid;
    logic [35:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_snoop;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [68:0] exp_q[$];
    logic [31:0] rv;

    always #2 clk = ~clk;

    pw_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_valid(link_valid),
        .link_ready(link_ready), .link_data(link_data), .link_err(link_err),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_snoop(mem_wr_snoop), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: every memory write must match the head of the expected queue (R3, R2, R5).
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2/R5: unexpected write got %h expected none",
                         {mem_wr_snoop, mem_wr_addr, mem_wr_data});
            end else begin
                logic [68:0] e;
                e = exp_q.pop_front();
                if ({mem_wr_snoop, mem_wr_addr, mem_wr_data} !== e) begin
                    bad++;
                    $display("FAIL R3: write got %h expected %h",
                             {mem_wr_snoop, mem_wr_addr, mem_wr_data}, e);
                end
            end
        end
    end

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Driver: sends 16 words; pushes expected writes when the packet should be stored.
    task automatic send_pkt(input logic [31:0] seed, input int gap, input bit expect_store,
                            input logic [35:0] base, input bit snp, input bit busy_chk);
        reg_addr = 2'd1;
        for (int i = 0; i < 16; i++) begin
            if (expect_store)
                exp_q.push_back({snp, base + 36'(4 * i), seed + 32'(i * 32'h01010101)});
            @(negedge clk);
            if (busy_chk && i == 8) chk("R10 busy mid-packet", 64'(reg_rdata[2]), 64'd1);
            link_valid = 1'b1;
            link_data  = seed + 32'(i * 32'h01010101);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                link_valid = 1'b0;
            end
        end
        @(negedge clk);
        link_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [35:0] base;
        base = {4'h3, 32'h1000_0040};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(2'd0, rv); chk("R1 mode", 64'(rv), 64'd0);
        rreg(2'd1, rv); chk("R1 status", 64'(rv), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 ready", 64'(link_ready), 64'd0);

        // R2 disabled: valid held high, no writes, ready low
        @(negedge clk); link_valid = 1'b1; link_data = 32'hDEAD0000;
        repeat (20) @(negedge clk);
        chk("R2 ready while disabled", 64'(link_ready), 64'd0);
        link_valid = 1'b0;

        // Configure and store packet A back-to-back (R3, R4, R10)
        wreg(2'd2, 32'h1000_0040);
        wreg(2'd3, 32'h0000_0003);
        wreg(2'd0, (32'd1 << 20) | (32'd1 << 8) | (32'd1 << 5) | 32'd1);
        chk("R2 ready when enabled", 64'(link_ready), 64'd1);
        send_pkt(32'hA000_0000, 0, 1'b1, base, 1'b1, 1'b1);
        chk("R3 all A words written", 64'(exp_q.size()), 64'd0);
        rreg(2'd1, rv); chk("R4 status after store", 64'(rv), 64'h0010_0010);
        chk("R9 irq on QFI", 64'(irq), 64'd1);

        // R5 packet while full is dropped
        send_pkt(32'hB000_0000, 0, 1'b0, base, 1'b1, 1'b0);
        rreg(2'd1, rv); chk("R5 discard set", 64'(rv), 64'h0010_0018);

        // R7 write 0 no effect, then W1C QFI and discard
        wreg(2'd1, 32'h0);
        rreg(2'd1, rv); chk("R7 write zero", 64'(rv), 64'h0010_0018);
        wreg(2'd1, 32'h0000_0010);
        rreg(2'd1, rv); chk("R7 QFI cleared, QF kept", 64'(rv), 64'h0010_0008);
        chk("R9 irq low after QFI clear", 64'(irq), 64'd0);
        wreg(2'd1, 32'h0000_0008);
        rreg(2'd1, rv); chk("R7 discard cleared", 64'(rv), 64'h0010_0000);

        // R6 clear-queue then store packet C with gaps and snoop off
        wreg(2'd0, (32'd1 << 8) | (32'd1 << 5) | 32'd1 | 32'd2);
        rreg(2'd0, rv); chk("R6 mode reads without clear bit", 64'(rv), 64'h0000_0121);
        rreg(2'd1, rv); chk("R6 queue released", 64'(rv), 64'd0);
        base = {4'h3, 32'h1000_0040};
        send_pkt(32'hC0C0_0000, 2, 1'b1, base, 1'b0, 1'b0);
        chk("R6 R3 packet C stored", 64'(exp_q.size()), 64'd0);
        rreg(2'd1, rv); chk("R4 status after C", 64'(rv), 64'h0010_0010);

        // R9 masking, R8 error handling
        wreg(2'd0, 32'h0000_0021);
        chk("R9 QFI masked", 64'(irq), 64'd0);
        @(negedge clk); link_err = 1'b1;
        @(negedge clk); link_err = 1'b0;
        rreg(2'd1, rv); chk("R8 error set", 64'(rv), 64'h0010_0090);
        chk("R9 irq on error", 64'(irq), 64'd1);
        wreg(2'd1, 32'h0000_0080);
        rreg(2'd1, rv); chk("R8 clear ignored while enabled", 64'(rv), 64'h0010_0090);
        wreg(2'd0, 32'h0);
        chk("R9 irq masked all", 64'(irq), 64'd0);
        wreg(2'd1, 32'h0000_0080);
        rreg(2'd1, rv); chk("R8 clear while disabled", 64'(rv), 64'h0010_0010);
        @(negedge clk); link_err = 1'b1;
        @(negedge clk); link_err = 1'b0;
        rreg(2'd1, rv); chk("R8 no set while disabled", 64'(rv), 64'h0010_0010);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard empty", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule